// File: doc/BRIEF.md
# Exception Arbiter and Context Save Unit

This block sits beside the program counter and machine-state logic of a small 32-bit core. Each cycle it looks at up to ten exception request lines and picks one by fixed priority. It sorts the chosen exception into one of three classes: reset, critical or noncritical. A hardware reset is separate from these request lines.

For a noncritical or critical exception, the unit saves a return address and the current machine state into one of two save/restore pairs. It then gives the core a redirect address and a new machine-state word, and both take effect from the first handler instruction. The new state is the old state with some enable bits cleared. A reset request loads fixed values and saves nothing.

The unit also carries out the two return operations. The normal return reloads the program counter and the machine state from the noncritical pair. The critical return reloads them from the critical pair.

The redirect, the new machine state and the exception code are combinational outputs in the cycle of the request. The save/restore registers update at the following rising clock edge.

Top module: `exc_ctx_unit`

## Requirements
- R1: Request line i (bit i of `reqVec`) has priority i, where 0 is the highest. The lines are: 0 reset, 1 machine check, 2 debug, 3 critical pin, 4 watchdog first timeout, 5 program/storage/TLB-miss/system-call, 6 alignment, 7 external, 8 fixed interval timer, 9 programmable interval timer. When an exception is taken, `excTaken` is 1 and `excCode` holds the lowest-numbered enabled pending line.
- R2: `excCritical` is 1 exactly when the taken exception has code 1, 2, 3 or 4. It is 0 for reset, for codes 5 to 9, and when nothing is taken.
- R3: Masking depends on two bits of `msrIn`:
  - Lines 1 to 4 are ignored while `msrIn` bit 17 (critical enable) is 0.
  - Lines 7 to 9 are ignored while `msrIn` bit 15 (external enable) is 0.
  - Lines 0, 5 and 6 are never masked.
  - When every pending line is masked, nothing is taken.
- R4: When a noncritical exception (code 5 to 9) is taken, save register 1 holds the value of `msrIn` after the next clock edge.
- R5: For a noncritical exception, save register 0 receives one of two addresses:
  - `curPc` when the code is 6, when the code is 5 with `isSysCall` at 0, or when `multiCycle` is 1.
  - `nextPc` in every other case.
- R6: When a critical exception is taken, save register 2 receives `nextPc` and save register 3 receives `msrIn` at the next edge. Save registers 0 and 1 keep their values.
- R7: When an exception is taken, `msrWe` and `redirectValid` are 1 in the same cycle. `msrOut` equals `msrIn` with bit 15 cleared. For a critical exception, bit 17 is cleared as well. All other bits are unchanged.
- R8: For codes 1 to 9, `redirectPc` equals `vecBase` plus code times `VEC_STRIDE` (default 256).
- R9: A taken reset request (code 0) drives `redirectPc` to `RST_PC` and `msrOut` to `RST_MSR`. No save register changes.
- R10: A normal return (`rfiStb`) with no exception taken drives `redirectPc` from save register 0 and `msrOut` from save register 1, with `redirectValid` and `msrWe` at 1.
- R11: A critical return (`rfciStb`) with no exception taken drives `redirectPc` from save register 2 and `msrOut` from save register 3. If both return strobes are high, the critical return wins.
- R12: When an exception is taken in the same cycle as a return strobe, the exception is served and the return has no effect.
- R13: In a cycle with no taken exception and no return, `redirectValid` and `msrWe` are 0 and no save register changes. Hardware reset (`rstN` low) clears all four save registers to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqVec | input | 10 | Exception request lines, bit index = priority |
| isSysCall | input | 1 | Line 5 request is a system call |
| multiCycle | input | 1 | A multicycle instruction is in progress |
| curPc | input | 32 | Address of the current instruction |
| nextPc | input | 32 | Next sequential instruction address |
| msrIn | input | 32 | Current machine state |
| vecBase | input | 32 | Handler vector base |
| rfiStb | input | 1 | Normal return strobe |
| rfciStb | input | 1 | Critical return strobe |
| excTaken | output | 1 | An exception is taken this cycle |
| excCode | output | 4 | Code of the taken exception |
| excCritical | output | 1 | Taken exception is critical |
| redirectValid | output | 1 | `redirectPc` is to be loaded |
| redirectPc | output | 32 | New program counter |
| msrWe | output | 1 | `msrOut` is to be loaded |
| msrOut | output | 32 | New machine state |
| srr0 | output | 32 | Noncritical saved return address |
| srr1 | output | 32 | Noncritical saved machine state |
| srr2 | output | 32 | Critical saved return address |
| srr3 | output | 32 | Critical saved machine state |

## Verification
The bench drives all ten lines at once under every combination of the two enable bits. This catches a priority encoder that favours the highest index, and masking applied to the wrong lines: either one shows up as a wrong `excCode` or as a missing redirect. It sets `isSysCall` and `multiCycle` against codes 5, 6 and 8, so a design that mixes up `curPc` and `nextPc` saves the wrong return address. It also sends returns into a cycle that already has a request, and asserts both return strobes together. A design that lets a return override an exception, or that reads the wrong save pair, produces a wrong `redirectPc` or `msrOut`.

// File: rtl/exc_ctx_pkg.sv
package exc_ctx_pkg;
  localparam int NUM_EXC  = 10;
  localparam int CODE_W   = $clog2(NUM_EXC);
  localparam int EE_BIT   = 15;
  localparam int CE_BIT   = 17;
  localparam int CRIT_LO  = 1;
  localparam int CRIT_HI  = 4;
  localparam int ASYNC_LO = 7;
  localparam int CODE_PRG = 5;
  localparam int CODE_ALN = 6;
  localparam int NUM_PAIR = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic              take;
    logic              isReset;
    logic              isCrit;
    logic              useCur;
    logic              doRfi;
    logic              doRfci;
    logic [CODE_W-1:0] code;
  } ctlStb_t;
endpackage

// File: rtl/exc_ctx_ctrl.sv
module exc_ctx_ctrl
  import exc_ctx_pkg::*;
(
  input  logic [NUM_EXC-1:0] reqVec,
  input  logic               isSysCall,
  input  logic               multiCycle,
  input  logic               eeOn,
  input  logic               ceOn,
  input  logic               rfiStb,
  input  logic               rfciStb,
  output ctlStb_t            stb
);
  logic [NUM_EXC-1:0] enMask;
  logic [NUM_EXC-1:0] live;
  logic               found;
  logic [CODE_W-1:0]  code;

  // per-line enable by class
  for (genvar i = 0; i < NUM_EXC; i++) begin : g_mask
    if (i >= CRIT_LO && i <= CRIT_HI) begin : g_crit
      assign enMask[i] = ceOn;
    end else if (i >= ASYNC_LO) begin : g_async
      assign enMask[i] = eeOn;
    end else begin : g_always
      assign enMask[i] = 1'b1;
    end
  end

  assign live = reqVec & enMask;

  // fixed priority: lowest index wins
  always_comb begin
    found = 1'b0;
    code  = '0;
    for (int i = NUM_EXC - 1; i >= 0; i--) begin
      if (live[i]) begin
        found = 1'b1;
        code  = CODE_W'(i);
      end
    end
  end

  always_comb begin
    stb         = '0;
    stb.take    = found;
    stb.code    = code;
    stb.isReset = found && (code == '0);
    stb.isCrit  = found && (code >= CODE_W'(CRIT_LO)) && (code <= CODE_W'(CRIT_HI));
    stb.useCur  = multiCycle || (code == CODE_W'(CODE_ALN)) ||
                  ((code == CODE_W'(CODE_PRG)) && !isSysCall);
    stb.doRfci  = !found && rfciStb;
    stb.doRfi   = !found && rfiStb && !rfciStb;
  end
endmodule

// File: rtl/exc_ctx_dpath.sv
module exc_ctx_dpath
  import exc_ctx_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          VEC_STRIDE = 256,
  parameter logic [XLEN-1:0] RST_PC  = '1,
  parameter logic [XLEN-1:0] RST_MSR = '0
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStb_t         stb,
  input  logic [XLEN-1:0] curPc,
  input  logic [XLEN-1:0] nextPc,
  input  logic [XLEN-1:0] msrIn,
  input  logic [XLEN-1:0] vecBase,
  output logic            redirectValid,
  output logic [XLEN-1:0] redirectPc,
  output logic            msrWe,
  output logic [XLEN-1:0] msrOut,
  output logic [XLEN-1:0] srr0,
  output logic [XLEN-1:0] srr1,
  output logic [XLEN-1:0] srr2,
  output logic [XLEN-1:0] srr3
);
  localparam logic [XLEN-1:0] EE_MASK = XLEN'(1) << EE_BIT;
  localparam logic [XLEN-1:0] CE_MASK = XLEN'(1) << CE_BIT;

  logic [NUM_PAIR-1:0] pairWr;
  logic [XLEN-1:0]     pairAddrIn [NUM_PAIR];
  logic [XLEN-1:0]     pairAddr   [NUM_PAIR];
  logic [XLEN-1:0]     pairMsr    [NUM_PAIR];
  logic [XLEN-1:0]     clrMask;
  logic [XLEN-1:0]     vecAddr;

  // pair 0 noncritical, pair 1 critical
  assign pairWr[0]     = stb.take && !stb.isReset && !stb.isCrit;
  assign pairWr[1]     = stb.take && stb.isCrit;
  assign pairAddrIn[0] = stb.useCur ? curPc : nextPc;
  assign pairAddrIn[1] = nextPc;

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pairAddr[p] <= '0;
        pairMsr[p]  <= '0;
      end else if (pairWr[p]) begin
        pairAddr[p] <= pairAddrIn[p];
        pairMsr[p]  <= msrIn;
      end
    end
  end

  assign srr0 = pairAddr[0];
  assign srr1 = pairMsr[0];
  assign srr2 = pairAddr[1];
  assign srr3 = pairMsr[1];

  assign clrMask = EE_MASK | (stb.isCrit ? CE_MASK : '0);
  assign vecAddr = vecBase + XLEN'(stb.code) * XLEN'(VEC_STRIDE);

  always_comb begin
    redirectValid = 1'b1;
    msrWe         = 1'b1;
    redirectPc    = vecAddr;
    msrOut        = msrIn & ~clrMask;
    if (stb.isReset) begin
      redirectPc = RST_PC;
      msrOut     = RST_MSR;
    end else if (stb.take) begin
      redirectPc = vecAddr;
    end else if (stb.doRfci) begin
      redirectPc = pairAddr[1];
      msrOut     = pairMsr[1];
    end else if (stb.doRfi) begin
      redirectPc = pairAddr[0];
      msrOut     = pairMsr[0];
    end else begin
      redirectValid = 1'b0;
      msrWe         = 1'b0;
      redirectPc    = nextPc;
      msrOut        = msrIn;
    end
  end
endmodule

// File: rtl/exc_ctx_unit.sv
module exc_ctx_unit
  import exc_ctx_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          VEC_STRIDE = 256,
  parameter logic [XLEN-1:0] RST_PC  = 32'hFFFF_FFFC,
  parameter logic [XLEN-1:0] RST_MSR = 32'h0000_0000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EXC-1:0] reqVec,
  input  logic               isSysCall,
  input  logic               multiCycle,
  input  logic [XLEN-1:0]    curPc,
  input  logic [XLEN-1:0]    nextPc,
  input  logic [XLEN-1:0]    msrIn,
  input  logic [XLEN-1:0]    vecBase,
  input  logic               rfiStb,
  input  logic               rfciStb,
  output logic               excTaken,
  output logic [CODE_W-1:0]  excCode,
  output logic               excCritical,
  output logic               redirectValid,
  output logic [XLEN-1:0]    redirectPc,
  output logic               msrWe,
  output logic [XLEN-1:0]    msrOut,
  output logic [XLEN-1:0]    srr0,
  output logic [XLEN-1:0]    srr1,
  output logic [XLEN-1:0]    srr2,
  output logic [XLEN-1:0]    srr3
);
  ctlStb_t stb;

  exc_ctx_ctrl u_ctrl (
    .reqVec     (reqVec),
    .isSysCall  (isSysCall),
    .multiCycle (multiCycle),
    .eeOn       (msrIn[EE_BIT]),
    .ceOn       (msrIn[CE_BIT]),
    .rfiStb     (rfiStb),
    .rfciStb    (rfciStb),
    .stb        (stb)
  );

  exc_ctx_dpath #(
    .XLEN       (XLEN),
    .VEC_STRIDE (VEC_STRIDE),
    .RST_PC     (RST_PC),
    .RST_MSR    (RST_MSR)
  ) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .curPc         (curPc),
    .nextPc        (nextPc),
    .msrIn         (msrIn),
    .vecBase       (vecBase),
    .redirectValid (redirectValid),
    .redirectPc    (redirectPc),
    .msrWe         (msrWe),
    .msrOut        (msrOut),
    .srr0          (srr0),
    .srr1          (srr1),
    .srr2          (srr2),
    .srr3          (srr3)
  );

  assign excTaken    = stb.take;
  assign excCode     = stb.take ? stb.code : '0;
  assign excCritical = stb.isCrit;
endmodule

// File: rtl/exc_ctx_chk.sv
module exc_ctx_chk
  import exc_ctx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_EXC-1:0] reqVec,
  input logic               rfiStb,
  input logic               rfciStb,
  input logic [XLEN-1:0]    nextPc,
  input logic [XLEN-1:0]    msrIn,
  input logic               excTaken,
  input logic [CODE_W-1:0]  excCode,
  input logic               excCritical,
  input logic               redirectValid,
  input logic [XLEN-1:0]    redirectPc,
  input logic               msrWe,
  input logic [XLEN-1:0]    msrOut,
  input logic [XLEN-1:0]    srr0,
  input logic [XLEN-1:0]    srr1,
  input logic [XLEN-1:0]    srr2,
  input logic [XLEN-1:0]    srr3
);
  // R1: the granted line is actually requested
  p_grant_req_r1: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |-> ((reqVec >> excCode) & NUM_EXC'(1)) != '0);

  // R2: critical flag only with a taken exception
  p_crit_taken_r2: assert property (@(posedge clk) disable iff (!rstN)
    excCritical |-> excTaken);

  // R7: critical exception masks both enables
  p_crit_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    (excTaken && excCritical) |-> (!msrOut[CE_BIT] && !msrOut[EE_BIT] && msrWe));

  // R6: critical save lands in pair 2/3 and leaves pair 0/1
  p_crit_save_r6: assert property (@(posedge clk) disable iff (!rstN)
    (excTaken && excCritical) |=> (srr2 == $past(nextPc) && srr3 == $past(msrIn)
                                   && $stable(srr0) && $stable(srr1)));

  // R9: reset request writes no save register
  p_reset_nosave_r9: assert property (@(posedge clk) disable iff (!rstN)
    (excTaken && excCode == '0) |=> ($stable(srr0) && $stable(srr1)
                                     && $stable(srr2) && $stable(srr3)));

  // R11: critical return restores from pair 2/3
  p_rfci_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rfciStb && !excTaken) |-> (redirectPc == srr2 && msrOut == srr3 && redirectValid));

  // R10: normal return restores from pair 0/1
  p_rfi_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rfiStb && !rfciStb && !excTaken) |-> (redirectPc == srr0 && msrOut == srr1 && msrWe));

  // R13: idle cycle drives nothing and saves nothing
  p_idle_r13: assert property (@(posedge clk) disable iff (!rstN)
    (!excTaken && !rfiStb && !rfciStb) |-> (!redirectValid && !msrWe));
  p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    !excTaken |=> ($stable(srr0) && $stable(srr1) && $stable(srr2) && $stable(srr3)));
endmodule

bind exc_ctx_unit exc_ctx_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/exc_ctx_unit_test.sv
`timescale 1ns/1ps
module exc_ctx_unit_test;
  import exc_ctx_pkg::*;

  localparam logic [31:0] RSTPC  = 32'hFFFF_FFFC;
  localparam logic [31:0] RSTMSR = 32'h0000_0000;
  localparam logic [31:0] EEM    = 32'h0000_8000;
  localparam logic [31:0] CEM    = 32'h0002_0000;

  logic        clk = 1'b0;
  logic        rstN;
  logic [9:0]  reqVec;
  logic        isSysCall, multiCycle, rfiStb, rfciStb;
  logic [31:0] curPc, nextPc, msrIn, vecBase;
  logic        excTaken, excCritical, redirectValid, msrWe;
  logic [3:0]  excCode;
  logic [31:0] redirectPc, msrOut, srr0, srr1, srr2, srr3;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;
  logic [31:0] mSrr [4];

  always #2 clk = ~clk;

  exc_ctx_unit #(.RST_PC(RSTPC), .RST_MSR(RSTMSR)) uut (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .isSysCall(isSysCall),
    .multiCycle(multiCycle), .curPc(curPc), .nextPc(nextPc), .msrIn(msrIn),
    .vecBase(vecBase), .rfiStb(rfiStb), .rfciStb(rfciStb),
    .excTaken(excTaken), .excCode(excCode), .excCritical(excCritical),
    .redirectValid(redirectValid), .redirectPc(redirectPc), .msrWe(msrWe),
    .msrOut(msrOut), .srr0(srr0), .srr1(srr1), .srr2(srr2), .srr3(srr3)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int pickExc(logic [9:0] r, logic [31:0] m);
    for (int i = 0; i < 10; i++) begin
      if (r[i]) begin
        if (i >= 1 && i <= 4) begin
          if (m[17]) return i;
        end else if (i >= 7) begin
          if (m[15]) return i;
        end else return i;
      end
    end
    return -1;
  endfunction

  task automatic checkSrr();
    chk("R5 srr0", srr0, mSrr[0]);
    chk("R4 srr1", srr1, mSrr[1]);
    chk("R6 srr2", srr2, mSrr[2]);
    chk("R6 srr3", srr3, mSrr[3]);
  endtask

  task automatic doCycle(input logic [9:0] r, input logic sc, input logic mc,
                         input logic [31:0] m, input logic fi, input logic fci,
                         input logic [31:0] pc);
    int  code;
    bit  crit;
    logic [31:0] ePc, eMsr;
    @(negedge clk);
    checkSrr();
    reqVec = r; isSysCall = sc; multiCycle = mc; msrIn = m;
    rfiStb = fi; rfciStb = fci; curPc = pc; nextPc = pc + 32'd4;
    #1;
    code = pickExc(r, m);
    crit = (code >= 1 && code <= 4);
    chk("R1 taken", {31'd0, excTaken}, {31'd0, code >= 0});
    chk("R1 code", {28'd0, excCode}, (code >= 0) ? code : 0);
    chk("R2 critical", {31'd0, excCritical}, {31'd0, crit});
    if (code == 0) begin
      chk("R9 pc", redirectPc, RSTPC);
      chk("R9 msr", msrOut, RSTMSR);
    end else if (code > 0) begin
      ePc  = vecBase + code * 256;
      eMsr = m & ~(EEM | (crit ? CEM : 32'd0));
      chk("R8 pc", redirectPc, ePc);
      chk("R7 msr", msrOut, eMsr);
      chk("R7 we", {30'd0, msrWe, redirectValid}, 32'd3);
      if (crit) begin
        mSrr[2] = nextPc; mSrr[3] = m;
      end else begin
        mSrr[0] = (mc || code == 6 || (code == 5 && !sc)) ? curPc : nextPc;
        mSrr[1] = m;
      end
    end else if (fci) begin
      chk("R11 pc", redirectPc, mSrr[2]);
      chk("R11 msr", msrOut, mSrr[3]);
      chk("R11 valid", {30'd0, msrWe, redirectValid}, 32'd3);
    end else if (fi) begin
      chk("R10 pc", redirectPc, mSrr[0]);
      chk("R10 msr", msrOut, mSrr[1]);
      chk("R10 valid", {30'd0, msrWe, redirectValid}, 32'd3);
    end else begin
      chk("R13 idle", {30'd0, msrWe, redirectValid}, 32'd0);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7319));
    for (int i = 0; i < 4; i++) mSrr[i] = '0;
    rstN = 1'b0; reqVec = '0; isSysCall = 0; multiCycle = 0;
    rfiStb = 0; rfciStb = 0; curPc = '0; nextPc = 32'd4;
    msrIn = '0; vecBase = 32'h0001_0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R13 reset state
    checkSrr();
    chk("R13 reset idle", {30'd0, msrWe, redirectValid}, 32'd0);
    rstN = 1'b1;

    // R1 R9: all lines pending, reset wins
    doCycle(10'h3FF, 0, 0, EEM | CEM | 32'h5, 0, 0, 32'h100);
    // R1 R6: all but reset, machine check wins
    doCycle(10'h3FE, 0, 0, EEM | CEM | 32'h5, 0, 0, 32'h200);
    // R3: critical masked, external taken
    doCycle(10'h09E, 0, 0, EEM, 0, 0, 32'h300);
    // R3: both masked, nothing taken
    doCycle(10'h39E, 0, 0, 32'h0, 0, 0, 32'h400);
    // R5: program non-syscall saves current, syscall saves next
    doCycle(10'h020, 0, 0, 32'h0, 0, 0, 32'h500);
    doCycle(10'h020, 1, 0, 32'h0, 0, 0, 32'h600);
    // R5: alignment saves current
    doCycle(10'h040, 1, 0, 32'h0, 0, 0, 32'h700);
    // R5: async with multicycle saves current, without saves next
    doCycle(10'h100, 0, 1, EEM, 0, 0, 32'h800);
    doCycle(10'h200, 0, 0, EEM, 0, 0, 32'h900);
    // R10 R11: both returns, critical wins; then normal return
    doCycle(10'h000, 0, 0, 32'h0, 1, 1, 32'hA00);
    doCycle(10'h000, 0, 0, 32'h0, 1, 0, 32'hB00);
    // R12: exception beats returns
    doCycle(10'h020, 0, 0, 32'h0, 1, 1, 32'hC00);
    doCycle(10'h004, 0, 0, CEM, 0, 1, 32'hD00);

    for (int n = 0; n < 3000; n++) begin
      logic [9:0] r;
      r = '0;
      for (int b = 0; b < 10; b++) r[b] = ($urandom_range(0, 11) == 0);
      vecBase = $urandom & 32'hFFFF_F000;
      doCycle(r, 1'($urandom), 1'($urandom_range(0, 3) == 0), $urandom,
              ($urandom_range(0, 3) == 0), ($urandom_range(0, 5) == 0),
              $urandom & 32'hFFFF_FFFC);
    end
    @(negedge clk);
    checkSrr();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule